// File: doc/BRIEF.md
# Byte-Queued SPI Master

This block is a register-mapped SPI master for a 32-bit word-access register bus. Software queues outgoing bytes in a 256-entry transmit queue; unless the master-inhibit control bit is set, the block sends every queued byte over SPI one at a time, most significant bit first, in mode 0. For each byte sent, the byte captured from the slave goes into a 256-entry receive queue, where software reads it back. A received byte that finds the receive queue full is dropped, and an overrun event pulse is raised for a separate interrupt block.

Chip-select outputs copy the low bits of a slave-select register that software writes directly. The control register also carries two self-clearing bits that empty either queue. A status register, two occupancy registers and a keyed soft reset complete the register set. Reading the receive data register with nothing queued returns a fixed marker value and changes nothing.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status register (0x64) reads 0x5, both occupancy registers read 0, every chip-select output is 1 and SCLK is low; SCLK stays low whenever no byte is being shifted.
- R2: A bus write of exactly 0x0000000A to 0x40 returns the whole block to its reset state (queues empty, inhibit clear, slave select all ones). Any other value written there changes nothing.
- R3: The control register is at 0x60. Bit 8 is master inhibit, is stored and reads back at bit 8. A 1 in bit 5 empties the transmit queue, a 1 in bit 6 empties the receive queue, and neither bit is stored, so both read back as 0.
- R4: Status at 0x64 reads bit 0 = receive queue empty, bit 1 = receive queue full, bit 2 = transmit queue empty, bit 3 = transmit queue full, other bits 0. Writes to 0x64 have no effect.
- R5: A write to 0x68 queues bits [7:0] of the write data. A write made while the transmit queue holds 256 bytes is dropped. On SPI each byte goes out MSB first in mode 0: MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R6: While inhibit is clear, queued bytes are sent back to back until the transmit queue is empty. While inhibit is set, no transfer starts and bytes stay queued. Clearing inhibit sends all of them.
- R7: Each byte captured from MISO is appended to the receive queue. Reading 0x6C returns the oldest entry in bits [7:0] (other bits 0) and removes it.
- R8: Reading 0x6C while the receive queue is empty returns 0xDEADBEEF and leaves the queue and status unchanged.
- R9: A byte captured while the receive queue holds 256 entries is dropped, ovr_evt pulses for one cycle, and the queued entries are kept.
- R10: Slave select at 0x70 holds a 32-bit value that resets to all ones and reads back. cs_n[i] equals bit i, so a 0 selects slave i.
- R11: The occupancy registers at 0x74 (transmit) and 0x78 (receive) read the entry count minus one, and read 0 when the queue is empty.
- R12: A read of any address not listed above, including an address that is not word aligned, returns 0. Read data appears in rsp_data with rsp_valid high on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| cs_n | output | NUM_CS | Chip selects, a 0 selects that slave |
| ovr_evt | output | 1 | One-cycle pulse when a received byte is dropped |

## Verification
The slave side of the bench drives MISO with the inverse of MOSI, so every received byte is the complement of the sent one. A mismatch then shows whether the wire order, the sample edge or the queue path is at fault. The main function is tried with a single byte sent while not inhibited, with a burst queued under inhibit and released by clearing it, with queues emptied through the control bits, and with a full 256-byte burst followed by one extra byte. The first pattern tests the low-byte selection and the bit order. The second tests the drain sequencing and order. The third tests the self-clearing resets. The last tests the full flags, the occupancy boundary values and overrun dropping.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam logic [7:0] OFF_SOFTRST = 8'h40;
    localparam logic [7:0] OFF_CTRL    = 8'h60;
    localparam logic [7:0] OFF_STATUS  = 8'h64;
    localparam logic [7:0] OFF_TXDATA  = 8'h68;
    localparam logic [7:0] OFF_RXDATA  = 8'h6C;
    localparam logic [7:0] OFF_SELECT  = 8'h70;
    localparam logic [7:0] OFF_TXOCC   = 8'h74;
    localparam logic [7:0] OFF_RXOCC   = 8'h78;

    localparam int CTRL_TXCLR_BIT   = 5;
    localparam int CTRL_RXCLR_BIT   = 6;
    localparam int CTRL_INHIBIT_BIT = 8;

    localparam logic [31:0] SOFTRST_KEY  = 32'h0000_000A;
    localparam logic [31:0] EMPTY_MARKER = 32'hDEAD_BEEF;

    typedef struct packed {
        logic        inhibit;
        logic [31:0] sel;
        logic [31:0] rdata;
        logic        rvalid;
    } regs_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    logic [WIDTH-1:0] mem [DEPTH];
    ptr_t q, d;
    logic do_push, do_pop;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wp = q.wp + 1'b1;
            if (do_pop)  d.rp = q.rp + 1'b1;
            if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
            else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= push_data;
    end

    assign head  = mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int HALF_DIV = 2,
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic          sclk;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic [7:0]    sho;
        logic [7:0]    shi;
    } shift_t;

    shift_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (abort) begin
            d.busy = 1'b0;
            d.sclk = 1'b0;
        end else if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sho  = tx_byte;
                d.bitn = '0;
                d.div  = '0;
                d.sclk = 1'b0;
            end
        end else if (q.div == DW'(HALF_DIV - 1)) begin
            d.div  = '0;
            d.sclk = !q.sclk;
            if (!q.sclk) begin
                d.shi = {q.shi[6:0], miso};
            end else if (q.bitn == 3'd7) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.sho  = {q.sho[6:0], 1'b0};
                d.bitn = q.bitn + 1'b1;
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_byte = q.shi;
    assign sclk    = q.sclk;
    assign mosi    = q.sho[7];
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int NUM_CS     = 1,
    parameter int FIFO_DEPTH = 256,
    parameter int HALF_DIV   = 2,
    parameter int ADDR_W     = 8,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ovr_evt
);
    regs_t q, d;

    logic wr, rd, soft_rst;
    logic tx_clr, rx_clr, tx_push, tx_pop, rx_push, rx_pop;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0] tx_head, rx_head, sh_rx;
    logic [CW-1:0] tx_count, rx_count;
    logic sh_busy, sh_done, sh_start;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    function automatic logic [31:0] occ(input logic [CW-1:0] c);
        return (c == '0) ? 32'd0 : 32'(c - 1'b1);
    endfunction

    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;
    assign soft_rst = wr && hit(bus_addr, OFF_SOFTRST) && (bus_wdata == SOFTRST_KEY);
    assign tx_clr   = soft_rst || (wr && hit(bus_addr, OFF_CTRL) && bus_wdata[CTRL_TXCLR_BIT]);
    assign rx_clr   = soft_rst || (wr && hit(bus_addr, OFF_CTRL) && bus_wdata[CTRL_RXCLR_BIT]);
    assign tx_push  = wr && hit(bus_addr, OFF_TXDATA);
    assign rx_pop   = rd && hit(bus_addr, OFF_RXDATA);
    assign sh_start = !q.inhibit && !tx_empty && !sh_busy && !tx_clr;
    assign tx_pop   = sh_start;
    assign rx_push  = sh_done;
    assign ovr_evt  = sh_done && rx_full && !rx_clr;

    byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .push_data(bus_wdata[7:0]),
        .pop(tx_pop), .head(tx_head), .count(tx_count),
        .empty(tx_empty), .full(tx_full)
    );

    byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .push_data(sh_rx),
        .pop(rx_pop), .head(rx_head), .count(rx_count),
        .empty(rx_empty), .full(rx_full)
    );

    spi_byte_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst),
        .start(sh_start), .tx_byte(tx_head), .miso(miso),
        .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx),
        .sclk(sclk), .mosi(mosi)
    );

    always_comb begin
        d = q;
        d.rvalid = rd;
        if (soft_rst) begin
            d.inhibit = 1'b0;
            d.sel     = '1;
        end else if (wr && hit(bus_addr, OFF_CTRL)) begin
            d.inhibit = bus_wdata[CTRL_INHIBIT_BIT];
        end else if (wr && hit(bus_addr, OFF_SELECT)) begin
            d.sel = bus_wdata;
        end
        if (rd) begin
            d.rdata = 32'd0;
            if (hit(bus_addr, OFF_CTRL))
                d.rdata[CTRL_INHIBIT_BIT] = q.inhibit;
            else if (hit(bus_addr, OFF_STATUS))
                d.rdata[3:0] = {tx_full, tx_empty, rx_full, rx_empty};
            else if (hit(bus_addr, OFF_RXDATA))
                d.rdata = rx_empty ? EMPTY_MARKER : {24'd0, rx_head};
            else if (hit(bus_addr, OFF_SELECT))
                d.rdata = q.sel;
            else if (hit(bus_addr, OFF_TXOCC))
                d.rdata = occ(tx_count);
            else if (hit(bus_addr, OFF_RXOCC))
                d.rdata = occ(rx_count);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.inhibit <= 1'b0;
            q.sel     <= '1;
            q.rdata   <= '0;
            q.rvalid  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rvalid;
    assign rsp_data  = q.rdata;
    assign cs_n      = q.sel[NUM_CS-1:0];
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
    parameter int NUM_CS = 1,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_data,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs_n,
    input logic              ovr_evt,
    input logic              rx_empty,
    input logic [CW-1:0]     rx_count,
    input logic              sh_busy,
    input logic              inhibit
);
    logic key_wr, empty_rd;
    assign key_wr   = bus_valid && bus_write && bus_addr == ADDR_W'(8'h40) && bus_wdata == 32'h0000_000A;
    assign empty_rd = bus_valid && !bus_write && bus_addr == ADDR_W'(8'h6C) && rx_empty;

    a_r2_key_reset_selects: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (cs_n == '1) && !inhibit);

    a_r8_empty_marker: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |=> rsp_valid && rsp_data == 32'hDEAD_BEEF && rx_empty);

    a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> !sclk);

    a_r9_overrun_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |-> rx_count == CW'(DEPTH));

    a_r6_inhibit_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !sh_busy) |=> !sh_busy);

    a_r12_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rsp_valid);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
    .NUM_CS(NUM_CS), .DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .sclk(sclk), .cs_n(cs_n), .ovr_evt(ovr_evt),
    .rx_empty(rx_empty), .rx_count(rx_count), .sh_busy(sh_busy), .inhibit(q.inhibit)
);

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
    localparam int NCS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0;
    logic bus_write = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic rsp_valid, sclk, mosi, miso, ovr_evt;
    logic [31:0] rsp_data;
    logic [NCS-1:0] cs_n;

    int checks = 0;
    int errors = 0;
    int ovr_cnt = 0;
    byte unsigned tx_q[$];
    byte unsigned rx_q[$];
    logic [7:0] mon_sh = '0;
    int mon_bits = 0;

    always #4 clk = !clk;

    assign miso = !mosi;

    spi_fifo_master #(.NUM_CS(NCS), .FIFO_DEPTH(256), .HALF_DIV(2), .ADDR_W(8)) u_spi_fifo_master (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .ovr_evt(ovr_evt)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FIFO-MASTER FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = rsp_valid ? rsp_data : 32'hxxxx_xxxx;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    // driver: queue a byte and record what the wire must carry
    task automatic send(input logic [31:0] v);
        bus_wr(8'h68, v);
        tx_q.push_back(v[7:0]);
    endtask

    task automatic read_rx(input string req);
        logic [31:0] v;
        byte unsigned e;
        bus_rd(8'h6C, v);
        e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
        check(req, v, {24'd0, e});
    endtask

    // monitor: rebuild each byte from MOSI at rising SCLK (R5, MSB first)
    always @(posedge sclk) begin
        byte unsigned e;
        mon_sh = {mon_sh[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            mon_bits = 0;
            e = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
            check("R5 wire byte", {24'd0, mon_sh}, {24'd0, e});
            if (rx_q.size() < 256) rx_q.push_back(~mon_sh);
        end
    end

    always @(posedge clk) if (ovr_evt) ovr_cnt++;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FIFO-MASTER FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd("R1 status", 8'h64, 32'h5);
        expect_rd("R11 tx occ empty", 8'h74, 32'h0);
        expect_rd("R11 rx occ empty", 8'h78, 32'h0);
        check("R10 cs_n reset", {29'd0, cs_n}, 32'h7);
        check("R1 sclk idle", {31'd0, sclk}, 32'h0);
        expect_rd("R10 select reset", 8'h70, 32'hFFFF_FFFF);

        // R12 unmapped and unaligned
        expect_rd("R12 unmapped 0x00", 8'h00, 32'h0);
        expect_rd("R12 unmapped 0x7C", 8'h7C, 32'h0);
        expect_rd("R12 key reg reads 0", 8'h40, 32'h0);
        expect_rd("R12 unaligned", 8'h72, 32'h0);

        // R4 status write ignored
        bus_wr(8'h64, 32'hF);
        expect_rd("R4 status write ignored", 8'h64, 32'h5);

        // R10 slave select
        bus_wr(8'h70, 32'hFFFF_FFFA);
        @(negedge clk);
        check("R10 cs_n follows bits", {29'd0, cs_n}, 32'h2);
        expect_rd("R10 select readback", 8'h70, 32'hFFFF_FFFA);

        // R2 keyed reset
        bus_wr(8'h40, 32'h0000_000B);
        @(negedge clk);
        check("R2 wrong key ignored", {29'd0, cs_n}, 32'h2);
        bus_wr(8'h40, 32'h0000_000A);
        @(negedge clk);
        check("R2 key resets select", {29'd0, cs_n}, 32'h7);

        // R5 single byte, only low byte used
        send(32'h1234_56A5);
        repeat (50) @(negedge clk);
        expect_rd("R4 rx not empty, tx empty", 8'h64, 32'h4);
        expect_rd("R11 one entry reads 0", 8'h78, 32'h0);
        read_rx("R7 received byte");
        expect_rd("R4 back to empty", 8'h64, 32'h5);

        // R6 inhibit queues, release drains
        bus_wr(8'h60, 32'h100);
        expect_rd("R3 inhibit stored", 8'h60, 32'h100);
        send(32'h11); send(32'h22); send(32'h33);
        repeat (120) @(negedge clk);
        expect_rd("R6 held while inhibited", 8'h74, 32'h2);
        expect_rd("R6 nothing received", 8'h64, 32'h1);
        bus_wr(8'h60, 32'h0);
        repeat (150) @(negedge clk);
        expect_rd("R6 all drained", 8'h64, 32'h4);
        expect_rd("R11 rx occ three", 8'h78, 32'h2);
        read_rx("R7 order first");
        read_rx("R7 order second");
        read_rx("R7 order third");
        expect_rd("R8 empty marker", 8'h6C, 32'hDEAD_BEEF);
        expect_rd("R8 status unchanged", 8'h64, 32'h5);
        expect_rd("R8 occ unchanged", 8'h78, 32'h0);

        // R3 self-clearing queue resets
        bus_wr(8'h60, 32'h100);
        send(32'h44); send(32'h55);
        bus_wr(8'h60, 32'h120);
        void'(tx_q.pop_front()); void'(tx_q.pop_front());
        expect_rd("R3 tx clear not stored", 8'h60, 32'h100);
        expect_rd("R3 tx queue emptied", 8'h64, 32'h5);
        bus_wr(8'h60, 32'h0);
        send(32'h66);
        repeat (50) @(negedge clk);
        bus_wr(8'h60, 32'h40);
        rx_q.delete();
        expect_rd("R3 rx queue emptied", 8'h64, 32'h5);
        expect_rd("R3 rx clear not stored", 8'h60, 32'h0);

        // R9 fill both queues, then overrun
        bus_wr(8'h60, 32'h100);
        for (int i = 0; i < 256; i++) send(i);
        expect_rd("R4 tx full", 8'h64, 32'h9);
        expect_rd("R11 tx occ full", 8'h74, 32'hFF);
        bus_wr(8'h68, 32'hEE);
        expect_rd("R5 write to full tx dropped", 8'h74, 32'hFF);
        bus_wr(8'h60, 32'h0);
        repeat (256 * 36 + 100) @(negedge clk);
        expect_rd("R4 rx full tx empty", 8'h64, 32'h6);
        expect_rd("R11 rx occ full", 8'h78, 32'hFF);
        check("R9 no overrun yet", ovr_cnt, 0);
        send(32'h77);
        repeat (60) @(negedge clk);
        check("R9 overrun pulse", ovr_cnt, 1);
        expect_rd("R9 rx kept", 8'h78, 32'hFF);
        read_rx("R9 oldest kept");
        read_rx("R9 second kept");
        check("R5 all queued bytes sent", tx_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule